// File: doc/BRIEF.md
# Block-Size Control Condition Decoder

This block sits in front of the sequencer of a shared row/column transform datapath. It takes the descriptor of one incoming coefficient block and reduces it to one registered control word. The descriptor gives the transform direction, whether the block is scaled (fewer rows sent) or sub-sampled (frequencies omitted), the number of rows present and a horizontal and a vertical size code. The control word holds a 20-bit condition vector with exactly one bit set per legal block shape, an error bit, the number of row-wise and column-wise passes, and the point length of the row and column transforms. The sequencer can then pick its schedule with a single bit test instead of repeated compare chains. The forward direction always works on full 8x8 blocks. Scaling and sub-sampling exist only in the inverse direction.

The control word is captured on the clock edge where `in_valid` is high and holds its value until the next such edge. A 2-bit size code maps to a dimension: 00 means 8, 01 means 4, 10 means 2 and 11 means 1. Size W comes from the horizontal code and size H from the vertical code.

Top module: `dctc_cond_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge, whatever the other inputs are.
- R2: The outputs take new values only on a rising edge where `in_valid` is high, and they hold their values on edges where it is low.
- R3: The size codes decode as 00=8, 01=4, 10=2, 11=1. The condition vector layout is fixed as follows. Bit 0 is the forward transform. Bit 1+4*hsize+vsize is the sub-sampled inverse shape, so bit 1 is full 8x8 and bit 2 is W=8 with H=4. Bit 16+vsize is the scaled inverse block, so bit 17 means four rows present, bit 18 two rows and bit 19 one row.
- R4: A forward request (`inv_mode`=0) is legal only with `scaled`=0, both size codes 00 and `row_count`=8. It sets bit 0, and all four counts/lengths read 8.
- R5: A sub-sampled inverse request (`inv_mode`=1, `scaled`=0) is legal when `row_count` equals H, for any horizontal code. It gives row passes = H, column passes = W, row length = W and column length = H.
- R6: A scaled inverse request (`inv_mode`=1, `scaled`=1) is legal only with horizontal code 00, vertical code not 00 and `row_count` equal to H. It gives row passes = H, column passes = 8, and row and column length 8.
- R7: Any other combination, including a row count of 0 or above 8, raises `err`. All 20 condition bits and all counts and lengths are then zero.
- R8: After every accepted descriptor, exactly one of the following is true: a single condition bit is set, or `err` is set. Two condition bits are never set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor strobe; the outputs load on edges where it is high |
| scaled | input | 1 | 1 = scaled block (rows omitted), 0 = full or sub-sampled |
| inv_mode | input | 1 | 1 = inverse transform, 0 = forward transform |
| row_count | input | 4 | Number of coefficient rows present (1..8) |
| hsize | input | 2 | Horizontal size code |
| vsize | input | 2 | Vertical size code |
| cond_flags | output | 20 | One-hot condition vector for the block shape |
| err | output | 1 | Illegal descriptor |
| row_passes | output | 4 | Number of row-wise transforms |
| col_passes | output | 4 | Number of column-wise transforms |
| row_len | output | 4 | Point length of each row transform |
| col_len | output | 4 | Point length of each column transform |

## Verification
A fault in the legality or shape decode shows at the ports on the edge after the strobe. It appears as a wrong bit position, two bits set, or an error bit set beside a shape bit. So every one of the 1024 descriptor combinations is applied and compared in full one cycle later. A fault in the capture register shows as outputs that change while the strobe is low. Random descriptors are therefore also driven with the strobe off, and the bench confirms that the outputs stay as they were on each of those cycles.

// File: rtl/dctc_pkg.sv
package dctc_pkg;
  localparam int SF_W     = 2;                  // width of a size code
  localparam int N_SF     = 1 << SF_W;          // number of size codes
  localparam int MAX_LOG  = N_SF - 1;           // log2 of the largest dimension
  localparam int MAX_DIM  = 1 << MAX_LOG;       // largest dimension (8)
  localparam int CNT_W    = MAX_LOG + 1;        // width of counts and lengths
  localparam int N_SUB    = N_SF * N_SF;        // sub-sampled shapes
  localparam int N_SCL    = N_SF - 1;           // scaled row counts
  localparam int N_FLAGS  = 1 + N_SUB + N_SCL;  // condition vector width
  localparam int SUB_BASE = 1;
  localparam int SCL_BASE = N_SUB;              // scaled bit = SCL_BASE + vsize

  typedef logic [SF_W-1:0]    sf_t;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [N_FLAGS-1:0] flags_t;

  typedef enum logic {XF_FWD = 1'b0, XF_INV = 1'b1} xf_mode_e;

  typedef struct packed {
    logic   err;
    flags_t flags;
    cnt_t   row_passes;
    cnt_t   col_passes;
    cnt_t   row_len;
    cnt_t   col_len;
  } ctl_word_t;

  function automatic cnt_t sf_dim(input sf_t code);
    return cnt_t'(MAX_DIM >> code);
  endfunction
endpackage

// File: rtl/dctc_legal.sv
module dctc_legal
  import dctc_pkg::*;
(
  input  logic xf_inv,
  input  logic scaled,
  input  cnt_t row_count,
  input  sf_t  hsize,
  input  sf_t  vsize,
  output logic fwd_ok,
  output logic sub_ok,
  output logic scl_ok
);
  xf_mode_e mode;
  logic     rows_match;
  logic     full_h;
  logic     full_v;

  always_comb begin
    mode       = xf_mode_e'(xf_inv);
    rows_match = (row_count == sf_dim(vsize));
    full_h     = (hsize == '0);
    full_v     = (vsize == '0);
    fwd_ok     = (mode == XF_FWD) && !scaled && full_h && full_v && rows_match;
    sub_ok     = (mode == XF_INV) && !scaled && rows_match;
    scl_ok     = (mode == XF_INV) && scaled && full_h && !full_v && rows_match;
  end
endmodule

// File: rtl/dctc_flag_gen.sv
module dctc_flag_gen
  import dctc_pkg::*;
(
  input  logic   fwd_ok,
  input  logic   sub_ok,
  input  logic   scl_ok,
  input  sf_t    hsize,
  input  sf_t    vsize,
  output flags_t flags
);
  assign flags[0] = fwd_ok;

  for (genvar h = 0; h < N_SF; h++) begin : g_h
    for (genvar v = 0; v < N_SF; v++) begin : g_v
      assign flags[SUB_BASE + h*N_SF + v] =
        sub_ok && (hsize == sf_t'(h)) && (vsize == sf_t'(v));
    end
  end

  for (genvar k = 1; k < N_SF; k++) begin : g_scl
    assign flags[SCL_BASE + k] = scl_ok && (vsize == sf_t'(k));
  end
endmodule

// File: rtl/dctc_geom.sv
module dctc_geom
  import dctc_pkg::*;
(
  input  logic fwd_ok,
  input  logic sub_ok,
  input  logic scl_ok,
  input  sf_t  hsize,
  input  sf_t  vsize,
  output cnt_t row_passes,
  output cnt_t col_passes,
  output cnt_t row_len,
  output cnt_t col_len
);
  cnt_t w_dim;
  cnt_t h_dim;

  always_comb begin
    w_dim      = sf_dim(hsize);
    h_dim      = sf_dim(vsize);
    row_passes = '0;
    col_passes = '0;
    row_len    = '0;
    col_len    = '0;
    if (fwd_ok) begin
      row_passes = cnt_t'(MAX_DIM);
      col_passes = cnt_t'(MAX_DIM);
      row_len    = cnt_t'(MAX_DIM);
      col_len    = cnt_t'(MAX_DIM);
    end else if (sub_ok) begin
      row_passes = h_dim;
      col_passes = w_dim;
      row_len    = w_dim;
      col_len    = h_dim;
    end else if (scl_ok) begin
      row_passes = h_dim;
      col_passes = cnt_t'(MAX_DIM);
      row_len    = cnt_t'(MAX_DIM);
      col_len    = cnt_t'(MAX_DIM);
    end
  end
endmodule

// File: rtl/dctc_cond_decoder.sv
module dctc_cond_decoder
  import dctc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 scaled,
  input  logic                 inv_mode,
  input  logic [CNT_W-1:0]     row_count,
  input  logic [SF_W-1:0]      hsize,
  input  logic [SF_W-1:0]      vsize,
  output logic [N_FLAGS-1:0]   cond_flags,
  output logic                 err,
  output logic [CNT_W-1:0]     row_passes,
  output logic [CNT_W-1:0]     col_passes,
  output logic [CNT_W-1:0]     row_len,
  output logic [CNT_W-1:0]     col_len
);
  logic      fwd_ok, sub_ok, scl_ok;
  ctl_word_t ctl_d, ctl_q;

  dctc_legal u_legal (
    .xf_inv    (inv_mode),
    .scaled    (scaled),
    .row_count (row_count),
    .hsize     (hsize),
    .vsize     (vsize),
    .fwd_ok    (fwd_ok),
    .sub_ok    (sub_ok),
    .scl_ok    (scl_ok)
  );

  dctc_flag_gen u_flags (
    .fwd_ok (fwd_ok),
    .sub_ok (sub_ok),
    .scl_ok (scl_ok),
    .hsize  (hsize),
    .vsize  (vsize),
    .flags  (ctl_d.flags)
  );

  dctc_geom u_geom (
    .fwd_ok     (fwd_ok),
    .sub_ok     (sub_ok),
    .scl_ok     (scl_ok),
    .hsize      (hsize),
    .vsize      (vsize),
    .row_passes (ctl_d.row_passes),
    .col_passes (ctl_d.col_passes),
    .row_len    (ctl_d.row_len),
    .col_len    (ctl_d.col_len)
  );

  assign ctl_d.err = !(fwd_ok || sub_ok || scl_ok);

  always_ff @(posedge clk) begin
    if (rst)           ctl_q <= '0;
    else if (in_valid) ctl_q <= ctl_d;
  end

  assign cond_flags = ctl_q.flags;
  assign err        = ctl_q.err;
  assign row_passes = ctl_q.row_passes;
  assign col_passes = ctl_q.col_passes;
  assign row_len    = ctl_q.row_len;
  assign col_len    = ctl_q.col_len;
endmodule

// File: rtl/dctc_cond_decoder_chk.sv
module dctc_cond_decoder_chk
  import dctc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [N_FLAGS-1:0] cond_flags,
  input logic               err,
  input logic [CNT_W-1:0]   row_passes,
  input logic [CNT_W-1:0]   col_passes,
  input logic [CNT_W-1:0]   row_len,
  input logic [CNT_W-1:0]   col_len
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cond_flags == '0 && !err && row_passes == '0 && col_len == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !rst) |=> ($stable(cond_flags) && $stable(err) &&
                             $stable(row_passes) && $stable(col_passes) &&
                             $stable(row_len) && $stable(col_len)));

  // R8
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cond_flags));

  // R8
  verdict_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> (err != (|cond_flags)));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (cond_flags == '0 && row_passes == '0 && col_passes == '0 &&
             row_len == '0 && col_len == '0));

  // R4
  fwd_len_chk: assert property (@(posedge clk) disable iff (rst)
    cond_flags[0] |-> (row_len == CNT_W'(MAX_DIM) && col_len == CNT_W'(MAX_DIM)));

  // R6
  scl_cols_chk: assert property (@(posedge clk) disable iff (rst)
    (|cond_flags[N_FLAGS-1:SCL_BASE+1]) |->
      (col_passes == CNT_W'(MAX_DIM) && row_len == CNT_W'(MAX_DIM)));
endmodule

bind dctc_cond_decoder dctc_cond_decoder_chk i_chk (.*);

// File: tb/test_dctc_cond_decoder.sv
`timescale 1ns/1ps
module test_dctc_cond_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        scaled = 1'b0;
  logic        inv_mode = 1'b0;
  logic [3:0]  row_count = '0;
  logic [1:0]  hsize = '0;
  logic [1:0]  vsize = '0;
  logic [19:0] cond_flags;
  logic        err;
  logic [3:0]  row_passes, col_passes, row_len, col_len;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dctc_cond_decoder i_dctc_cond_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .scaled(scaled),
    .inv_mode(inv_mode), .row_count(row_count), .hsize(hsize), .vsize(vsize),
    .cond_flags(cond_flags), .err(err), .row_passes(row_passes),
    .col_passes(col_passes), .row_len(row_len), .col_len(col_len)
  );

  // {err, flags[19:0], row_passes, col_passes, row_len, col_len}
  function automatic logic [36:0] model(input logic se, input logic inv,
                                        input logic [3:0] rows,
                                        input logic [1:0] h, input logic [1:0] v);
    int w  = 8 >> h;
    int hh = 8 >> v;
    logic [19:0] f = '0;
    logic [3:0] rp = 0, cp = 0, rl = 0, cl = 0;
    logic ok = 1'b0;
    if (!inv) begin
      if (!se && h == 0 && v == 0 && rows == 4'd8) begin
        ok = 1'b1; f[0] = 1'b1; rp = 8; cp = 8; rl = 8; cl = 8;
      end
    end else if (!se) begin
      if (int'(rows) == hh) begin
        ok = 1'b1; f[1 + 4*h + v] = 1'b1;
        rp = 4'(hh); cp = 4'(w); rl = 4'(w); cl = 4'(hh);
      end
    end else begin
      if (h == 0 && v != 0 && int'(rows) == hh) begin
        ok = 1'b1; f[16 + v] = 1'b1;
        rp = 4'(hh); cp = 8; rl = 8; cl = 8;
      end
    end
    return {!ok, f, rp, cp, rl, cl};
  endfunction

  function automatic logic [36:0] dut_word();
    return {err, cond_flags, row_passes, col_passes, row_len, col_len};
  endfunction

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic se, input logic inv, input logic [36:0] e);
    if (e[36]) return "R7";
    if (!inv)  return "R4";
    if (se)    return "R6";
    return "R5";
  endfunction

  task automatic drive(input logic vld, input logic se, input logic inv,
                       input logic [3:0] rows, input logic [1:0] h, input logic [1:0] v);
    @(negedge clk);
    in_valid = vld; scaled = se; inv_mode = inv;
    row_count = rows; hsize = h; vsize = v;
  endtask

  // apply a strobed descriptor and compare one edge later
  task automatic apply_chk(input logic se, input logic inv, input logic [3:0] rows,
                           input logic [1:0] h, input logic [1:0] v);
    logic [36:0] e;
    drive(1'b1, se, inv, rows, h, v);
    e = model(se, inv, rows, h, v);
    @(negedge clk);
    in_valid = 1'b0;
    check(req_of(se, inv, e), dut_word(), e);
    // R8: single flag or error, never both
    n_checks++;
    if (!((err && cond_flags == '0) || (!err && $countones(cond_flags) == 1))) begin
      n_errors++;
      $display("FAIL R8: actual flags=%h err=%b expected one-hot xor err", cond_flags, err);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [36:0] held;
    void'($urandom(32'h5eed_d0c7));
    // R1: legal descriptor strobed during reset must not load
    drive(1'b1, 1'b0, 1'b1, 4'd8, 2'd0, 2'd0);
    @(negedge clk);
    @(negedge clk);
    check("R1", dut_word(), 37'd0);
    rst = 1'b0; in_valid = 1'b0;

    // R3 directed: size-code decode and fixed bit positions
    apply_chk(1'b0, 1'b1, 4'd4, 2'b00, 2'b01);
    check("R3 bit2", {36'd0, cond_flags[2]}, 37'd1);
    apply_chk(1'b1, 1'b1, 4'd4, 2'b00, 2'b01);
    check("R3 bit17", {36'd0, cond_flags[17]}, 37'd1);
    apply_chk(1'b0, 1'b1, 4'd1, 2'b11, 2'b11);
    check("R3 bit16 len", {cond_flags[16], 32'd0, row_len}, {1'b1, 32'd0, 4'd1});
    // R7 corner cases: zero rows, too many rows, forward with scaling
    apply_chk(1'b0, 1'b1, 4'd0, 2'b00, 2'b00);
    apply_chk(1'b0, 1'b1, 4'd15, 2'b00, 2'b00);
    apply_chk(1'b1, 1'b0, 4'd8, 2'b00, 2'b00);
    apply_chk(1'b1, 1'b1, 4'd8, 2'b00, 2'b00);

    // R4 R5 R6 R7 R8: full sweep of every descriptor
    for (int se = 0; se < 2; se++)
      for (int inv = 0; inv < 2; inv++)
        for (int rows = 0; rows < 16; rows++)
          for (int h = 0; h < 4; h++)
            for (int v = 0; v < 4; v++)
              apply_chk(1'(se), 1'(inv), 4'(rows), 2'(h), 2'(v));

    // R2: random descriptors; non-strobed ones must leave outputs unchanged
    for (int it = 0; it < 300; it++) begin
      logic [3:0] rr;
      rr = ($urandom % 2) ? 4'(8 >> ($urandom % 4)) : 4'($urandom % 16);
      apply_chk(1'($urandom), 1'($urandom), rr, 2'($urandom), 2'($urandom));
      held = dut_word();
      for (int k = 0; k < 3; k++) begin
        drive(1'b0, 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom), 2'($urandom));
        @(negedge clk);
        check("R2 hold", dut_word(), held);
      end
    end

    // R1: reset mid-run clears a loaded word
    apply_chk(1'b0, 1'b0, 4'd8, 2'd0, 2'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 midrun", dut_word(), 37'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule